// File: doc/BRIEF.md
# Periodic Second Insert/Swallow Trimmer

The trimmer sits between a raw one-second pulse source and a seconds counter. It corrects crystal drift by whole seconds. Every raw pulse becomes one increment strobe whose step size is normally 1. When correction is armed, the pulse that closes each interval of `match+1` seconds gets a different step size. Insert mode gives that pulse a step of 2, which speeds the clock up. Swallow mode gives it a step of 0, which slows the clock down. The correction strength is 1e9/(match+1) parts per billion.

A single 32-bit configuration word programs the block, using a write strobe. Each write replaces the stored setting and restarts the interval. The seconds counter that consumes the steps and the bus decode that produces the write strobe are outside this block.

Top module: `sec_trimmer`

## Requirements
- R1: After reset every output is 0. The stored setting is disarmed, so raw pulses pass through with a step of 1 until the first write.
- R2: Each raw pulse on `pulse_i` gives exactly one `tick_o` strobe one clock later. No strobe occurs in a cycle that follows a cycle without a pulse.
- R3: When bit 23 (arm) of the stored word is 0, every strobe has step 1 and `insert_o` and `swallow_o` stay 0.
- R4: With arm set, a mode code (bits 20:19) of 0 or 1 behaves exactly as disarmed.
- R5: With arm set and mode code 3 (insert), the interval counter counts the match value (bits 18:0) over the range 0 to 2^19-1. The (match+1)-th pulse after a write, and every (match+1)-th pulse after that, gives step 2 with `insert_o` high. All other pulses give step 1.
- R6: With arm set and mode code 2 (swallow), the pulses selected as in R5 give step 0 with `swallow_o` high.
- R7: A match value of 0 makes every pulse a corrected one.
- R8: A write restarts the interval, so pulses seen before the write do not count toward the next correction.
- R9: A pulse in the same cycle as a write gives a step of 1. The new interval starts counting from the next pulse.
- R10: `insert_o` and `swallow_o` are never both high. `insert_o` comes only with step 2, and `swallow_o` comes only with step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | Raw one-second pulse, one cycle wide |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 32 | Configuration word: [18:0] match, [20:19] mode code, [23] arm |
| tick_o | output | 1 | Increment strobe, one per raw pulse |
| step_o | output | 2 | Step size for this strobe: 0, 1 or 2 |
| insert_o | output | 1 | Strobe carried an inserted second |
| swallow_o | output | 1 | Strobe carried a swallowed second |

## Verification
Directed sequences cover four cases: disarmed operation, both inert mode codes, match 0, and a long match of 1000 driven with back-to-back pulses. Together these separate pass-through from correction and test a long counter run. Further sequences re-write the configuration in the middle of an interval and issue a write in the same cycle as a pulse. These catch a counter that is not cleared and a pulse that is counted twice across the write. The random phases use sparse, irregular pulse gaps with random match values, mode codes and occasional rewrites. They check that the correction follows the pulse count and not the elapsed cycles.

// File: rtl/sec_trim_pkg.sv
package sec_trim_pkg;
  typedef enum logic [1:0] {
    TRIM_OFF     = 2'd0,
    TRIM_SWALLOW = 2'd1,
    TRIM_INSERT  = 2'd2
  } trim_mode_e;

  localparam logic [1:0] CODE_SWALLOW = 2'd2;
  localparam logic [1:0] CODE_INSERT  = 2'd3;
endpackage

// File: rtl/trim_cfg_reg.sv
module trim_cfg_reg
  import sec_trim_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MATCH_W   = 19,
  parameter int CODE_LSB  = 19,
  parameter int ARM_POS   = 23
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [MATCH_W-1:0] match_o,
  output trim_mode_e         mode_o
);
  logic [MATCH_W-1:0] match_q;
  logic [1:0]         code_q;
  logic               arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      code_q  <= '0;
      arm_q   <= 1'b0;
    end else if (wr_i) begin
      match_q <= data_i[MATCH_W-1:0];
      code_q  <= data_i[CODE_LSB +: 2];
      arm_q   <= data_i[ARM_POS];
    end
  end

  // codes 0 and 1 are inert
  always_comb begin
    mode_o = TRIM_OFF;
    if (arm_q) begin
      unique case (code_q)
        CODE_SWALLOW: mode_o = TRIM_SWALLOW;
        CODE_INSERT:  mode_o = TRIM_INSERT;
        default:      mode_o = TRIM_OFF;
      endcase
    end
  end

  assign match_o = match_q;
endmodule

// File: rtl/trim_interval.sv
module trim_interval #(
  parameter int MATCH_W = 19
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               pulse_i,
  input  logic [MATCH_W-1:0] match_i,
  output logic               wrap_o
);
  logic [MATCH_W-1:0] cnt_q;

  assign wrap_o = pulse_i && !clr_i && (cnt_q == match_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (pulse_i)  cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/trim_step.sv
module trim_step
  import sec_trim_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pulse_i,
  input  logic       wrap_i,
  input  trim_mode_e mode_i,
  output logic       tick_o,
  output logic [1:0] step_o,
  output logic       insert_o,
  output logic       swallow_o
);
  logic       do_ins, do_swl;
  logic [1:0] step_d;

  assign do_ins = pulse_i && wrap_i && (mode_i == TRIM_INSERT);
  assign do_swl = pulse_i && wrap_i && (mode_i == TRIM_SWALLOW);

  always_comb begin
    step_d = '0;
    if (pulse_i) step_d = do_ins ? 2'd2 : (do_swl ? 2'd0 : 2'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_o    <= 1'b0;
      step_o    <= '0;
      insert_o  <= 1'b0;
      swallow_o <= 1'b0;
    end else begin
      tick_o    <= pulse_i;
      step_o    <= step_d;
      insert_o  <= do_ins;
      swallow_o <= do_swl;
    end
  end
endmodule

// File: rtl/sec_trimmer.sv
module sec_trimmer
  import sec_trim_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MATCH_W = 19,
  parameter int ARM_POS = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic              cfg_wr_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  output logic              tick_o,
  output logic [1:0]        step_o,
  output logic              insert_o,
  output logic              swallow_o
);
  localparam int CODE_LSB = MATCH_W;

  logic [MATCH_W-1:0] match;
  trim_mode_e         mode;
  logic               wrap;

  trim_cfg_reg #(
    .DATA_W  (DATA_W),
    .MATCH_W (MATCH_W),
    .CODE_LSB(CODE_LSB),
    .ARM_POS (ARM_POS)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cfg_wr_i),
    .data_i (cfg_data_i),
    .match_o(match),
    .mode_o (mode)
  );

  trim_interval #(.MATCH_W(MATCH_W)) u_int (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_wr_i),
    .pulse_i(pulse_i),
    .match_i(match),
    .wrap_o (wrap)
  );

  trim_step u_step (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pulse_i  (pulse_i),
    .wrap_i   (wrap),
    .mode_i   (mode),
    .tick_o   (tick_o),
    .step_o   (step_o),
    .insert_o (insert_o),
    .swallow_o(swallow_o)
  );
endmodule

// File: rtl/sec_trimmer_chk.sv
module sec_trimmer_chk
  import sec_trim_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pulse_i,
  input logic       cfg_wr_i,
  input trim_mode_e mode,
  input logic       tick_o,
  input logic [1:0] step_o,
  input logic       insert_o,
  input logic       swallow_o
);
  // R2
  tick_follows_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> tick_o);
  // R2
  no_spurious_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> !tick_o);
  // R3
  off_passes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !cfg_wr_i && mode == TRIM_OFF) |=> (step_o == 2'd1 && !insert_o && !swallow_o));
  // R9
  write_pulse_plain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && cfg_wr_i) |=> (step_o == 2'd1));
  // R10
  flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(insert_o && swallow_o));
  // R10
  insert_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insert_o |-> (tick_o && step_o == 2'd2));
  // R10
  swallow_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swallow_o |-> (tick_o && step_o == 2'd0));
endmodule

bind sec_trimmer sec_trimmer_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pulse_i  (pulse_i),
  .cfg_wr_i (cfg_wr_i),
  .mode     (mode),
  .tick_o   (tick_o),
  .step_o   (step_o),
  .insert_o (insert_o),
  .swallow_o(swallow_o)
);

// File: tb/sec_trimmer_test.sv
module sec_trimmer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulse = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] data = '0;
  logic        tick, ins, swl;
  logic [1:0]  step;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  sec_trimmer uut (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse), .cfg_wr_i(wr), .cfg_data_i(data),
    .tick_o(tick), .step_o(step), .insert_o(ins), .swallow_o(swl)
  );

  // reference model state
  int unsigned m_cnt = 0, m_match = 0;
  bit          m_arm = 0;
  bit [1:0]    m_code = 0;
  bit          have_exp = 0;
  bit          e_tick, e_ins, e_swl;
  bit [1:0]    e_step;
  string       e_tag, cur_tag = "R1";

  function automatic logic [31:0] mk_cfg(bit arm, bit [1:0] code, int unsigned match);
    logic [31:0] v = '0;
    v[18:0]  = match[18:0];
    v[20:19] = code;
    v[23]    = arm;
    return v;
  endfunction

  function automatic bit [1:0] exp_step(bit arm, bit [1:0] code, bit wrap);
    if (wrap && arm && code == 2'd3) return 2'd2;
    if (wrap && arm && code == 2'd2) return 2'd0;
    return 2'd1;
  endfunction

  task automatic report;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check_prev;
    if (!have_exp) return;
    checks++;
    if (tick !== e_tick || step !== e_step || ins !== e_ins || swl !== e_swl) begin
      errors++;
      $display("FAIL %s: got tick=%b step=%0d ins=%b swl=%b exp tick=%b step=%0d ins=%b swl=%b",
               e_tag, tick, step, ins, swl, e_tick, e_step, e_ins, e_swl);
    end
  endtask

  task automatic cyc(bit p, bit w, logic [31:0] d);
    bit wrap;
    @(negedge clk);
    check_prev();
    pulse = p; wr = w; data = d;
    e_tick = p; e_step = p ? 2'd1 : 2'd0; e_ins = 0; e_swl = 0; e_tag = cur_tag;
    if (w) begin
      if (p) e_tag = "R9";
      m_cnt = 0; m_match = d[18:0]; m_code = d[20:19]; m_arm = d[23];
    end else if (p) begin
      wrap = (m_cnt == m_match);
      m_cnt = wrap ? 0 : m_cnt + 1;
      e_step = exp_step(m_arm, m_code, wrap);
      e_ins = (e_step == 2'd2);
      e_swl = (e_step == 2'd0);
      if (e_ins) e_tag = (m_match == 0) ? "R7" : "R5";
      if (e_swl) e_tag = (m_match == 0) ? "R7" : "R6";
    end
    have_exp = 1;
  endtask

  task automatic run_rand(int n, int gap_max);
    for (int i = 0; i < n; i++) cyc(($urandom % (gap_max + 1)) == 0, 1'b0, '0);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin cyc(1'b1, 1'b0, '0); cyc(1'b0, 1'b0, '0); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got hung run exp completion");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (tick !== 0 || step !== 0 || ins !== 0 || swl !== 0) begin
      errors++;
      $display("FAIL R1: got tick=%b step=%0d ins=%b swl=%b exp all 0", tick, step, ins, swl);
    end
    rst_n = 1'b1;
    cur_tag = "R1";
    pulses(5);
    cur_tag = "R2"; run_rand(60, 2);

    // R3: disarmed with insert code and match 0
    cur_tag = "R3"; cyc(0, 1, mk_cfg(0, 2'd3, 0)); run_rand(80, 1);
    // R4: inert codes
    cur_tag = "R4"; cyc(0, 1, mk_cfg(1, 2'd0, 0)); run_rand(60, 1);
    cyc(0, 1, mk_cfg(1, 2'd1, 1)); run_rand(60, 1);
    // R7 insert and swallow with match 0
    cur_tag = "R7"; cyc(0, 1, mk_cfg(1, 2'd3, 0)); pulses(6);
    cyc(0, 1, mk_cfg(1, 2'd2, 0)); pulses(6);
    // R5 insert match 4, R6 swallow match 3
    cur_tag = "R5"; cyc(0, 1, mk_cfg(1, 2'd3, 4)); run_rand(120, 3);
    cur_tag = "R6"; cyc(0, 1, mk_cfg(1, 2'd2, 3)); run_rand(120, 3);
    // R8: rewrite mid-interval restarts count
    cur_tag = "R8"; cyc(0, 1, mk_cfg(1, 2'd3, 4)); pulses(3);
    cyc(0, 1, mk_cfg(1, 2'd3, 4)); pulses(12);
    // R9: write coinciding with pulse
    cur_tag = "R9"; cyc(1, 1, mk_cfg(1, 2'd2, 2)); pulses(7);
    cyc(1, 1, mk_cfg(1, 2'd3, 0)); pulses(3);
    // R5 long interval, back-to-back pulses
    cur_tag = "R5"; cyc(0, 1, mk_cfg(1, 2'd3, 1000));
    for (int i = 0; i < 2100; i++) cyc(1'b1, 1'b0, '0);
    // random mix, including mid-run rewrites
    cur_tag = "R2";
    for (int r = 0; r < 60; r++) begin
      cyc($urandom % 2, 1'b1, mk_cfg($urandom % 4 != 0, $urandom % 4, $urandom % 12));
      for (int i = 0; i < 150; i++) begin
        if (($urandom % 97) == 0)
          cyc($urandom % 2, 1'b1, mk_cfg(1, 2'd2 + ($urandom % 2), $urandom % 6));
        else
          cyc(($urandom % 3) == 0, 1'b0, '0);
      end
    end
    cyc(0, 0, '0);
    @(negedge clk);
    check_prev();
    report();
  end
endmodule